// File: doc/BRIEF.md
# Dual-Bank Flash Fetch Accelerator

This block sits between a 32-bit processor port and two flash banks. The port carries instruction fetches and data loads. Each bank returns a 128-bit line, which is four 32-bit words. Line address bit 0 (byte address bit 4) picks the bank, so consecutive 16-byte lines alternate between the two banks. Each bank keeps two 128-bit lines: a branch-trail line, filled by the last instruction miss in that bank, and a prefetch line, filled by a speculative read. Both banks share one data line, which is filled by data misses. Data reads are never prefetched.

A mode register selects how much of this buffering is used. In the off mode every access reads the flash. In the partial mode only sequential instruction hits are served early, and every other access takes the full flash time. In the full mode any code or data hit is served at once. A timing register sets the flash access length to 1 to 7 clocks. A program-start strobe clears every buffer. While the flash is busy, the request port does not accept new requests.

A request is accepted when `req_valid_i` and `req_ready_o` are both high on a clock edge. Only one request is outstanding at a time. The response is a one-cycle pulse on `rsp_valid_o`.

Top module: `fetch_accel`

## Requirements
- R1: After reset the mode is off (00) and the access length is 7. `req_ready_o` is high and `rsp_valid_o` is low, and the first access responds 7 clocks after its acceptance edge.
- R2: In mode 00 every access is slow, even a repeated access to the same line. A slow access responds exactly T clocks after the acceptance edge, where T is the access length. A fast access responds in the cycle right after the acceptance edge.
- R3: In mode 01, an instruction access with `req_seq_i`=1 that hits a bank line is fast. A non-sequential instruction hit is slow, and every data access is slow.
- R4: In mode 10, an instruction hit in the bank selected by the address is fast, and so is a data hit in the shared data line. The data line holds only the line of the last data miss, matched on all 13 line-address bits.
- R5: A write of 1 to 7 to the timing register sets T for accesses and prefetches that start afterwards. A write of 0 is ignored.
- R6: A mode write of 11 is ignored. A mode write that changes the mode clears all buffers. A write of the current mode keeps them.
- R7: In modes 01 and 10, when an instruction miss on line L completes, the opposite bank starts a prefetch of line L+1. That prefetch completes T edges later, and an access accepted after completion hits. A slow access to a bank cancels that bank's unfinished prefetch.
- R8: In modes 01 and 10, delivering an instruction from word 3 (address bits 3:2 = 11) of line L starts a prefetch of line L+2 in the same bank.
- R9: `prog_start_i` clears every buffer. While `flash_busy_i` is high, `req_ready_o` is low.
- R10: The response word is word address[3:2] of the 128-bit line at address[AW-1:4]. Word 0 is bits 31:0.
- R11: Byte address bit 4 selects the bank. Bank b line tag t is line index {t,b}, and `fl_addr_o` carries bank b's tag in bits [b*(AW-5) +: AW-5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 2 | Mode value: 00 off, 01 partial, 10 full |
| tim_we_i | input | 1 | Timing register write strobe |
| tim_i | input | 3 | Flash access length in clocks |
| prog_start_i | input | 1 | Program or erase start pulse |
| flash_busy_i | input | 1 | Flash programming in progress |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | AW | Byte address |
| req_data_i | input | 1 | 1 = data load, 0 = instruction fetch |
| req_seq_i | input | 1 | Instruction fetch is sequential |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Response word |
| fl_en_o | output | 2 | Per-bank read active |
| fl_addr_o | output | 2*(AW-5) | Per-bank line tag |
| fl_rdata_i | input | 256 | Per-bank line data, bank b at [b*128 +: 128] |

## Verification
The hardest case to reach is a request that arrives while a speculative prefetch is only partly done, or just after it finishes. Whether that request hits or cancels the prefetch depends on the exact edge at which the prefetch was started. The bench places requests after counted idle gaps after a miss, including back-to-back requests, while a reference model tracks the start edge of each bank's prefetch. This covers both sides of the completion boundary and the word-3 chaining into the next line.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int WORD_W = 32;
  localparam int WORDS  = 4;
  localparam int LINE_W = WORD_W * WORDS;
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int WSEL_W = $clog2(WORDS);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PART = 2'b01,
    MODE_FULL = 2'b10
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/fa_bank.sv
module fa_bank
  import fa_pkg::*;
#(
  parameter int TAG_W = 12,
  parameter int TIM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIM_W-1:0]  tim_i,
  input  logic              inval_i,
  input  logic              cancel_i,
  input  logic              pf_start_i,
  input  logic [TAG_W-1:0]  pf_tag_i,
  input  logic              dem_act_i,
  input  logic [TAG_W-1:0]  dem_tag_i,
  input  logic              bt_fill_i,
  input  logic [LINE_W-1:0] fl_rdata_i,
  output logic              fl_en_o,
  output logic [TAG_W-1:0]  fl_addr_o,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] hit_line_o,
  output logic              pf_act_o
);
  logic              pf_valid_q, pf_act_q, bt_valid_q;
  logic [TAG_W-1:0]  pf_tag_q, bt_tag_q;
  logic [LINE_W-1:0] pf_line_q, bt_line_q;
  logic [TIM_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_q <= 1'b0;
      pf_act_q   <= 1'b0;
      bt_valid_q <= 1'b0;
      pf_tag_q   <= '0;
      bt_tag_q   <= '0;
      pf_line_q  <= '0;
      bt_line_q  <= '0;
      cnt_q      <= '0;
    end else if (inval_i) begin
      pf_valid_q <= 1'b0;
      pf_act_q   <= 1'b0;
      bt_valid_q <= 1'b0;
    end else begin
      if (bt_fill_i) begin
        bt_valid_q <= 1'b1;
        bt_tag_q   <= dem_tag_i;
        bt_line_q  <= fl_rdata_i;
      end
      if (cancel_i) begin
        pf_act_q <= 1'b0;
      end else if (pf_start_i) begin
        pf_act_q   <= 1'b1;
        pf_valid_q <= 1'b0;
        pf_tag_q   <= pf_tag_i;
        cnt_q      <= tim_i;
      end else if (pf_act_q) begin
        if (cnt_q == TIM_W'(1)) begin
          pf_act_q   <= 1'b0;
          pf_valid_q <= 1'b1;
          pf_line_q  <= fl_rdata_i;
        end else begin
          cnt_q <= cnt_q - TIM_W'(1);
        end
      end
    end
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_line_o = bt_line_q;
    if (pf_valid_q && pf_tag_q == lk_tag_i) begin
      hit_o      = 1'b1;
      hit_line_o = pf_line_q;
    end else if (bt_valid_q && bt_tag_q == lk_tag_i) begin
      hit_o = 1'b1;
    end
  end

  assign fl_en_o   = dem_act_i | pf_act_q;
  assign fl_addr_o = dem_act_i ? dem_tag_i : pf_tag_q;
  assign pf_act_o  = pf_act_q;

  AST_INVAL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (!pf_valid_q && !bt_valid_q && !pf_act_q)); // R9
endmodule

// File: rtl/fa_dline.sv
module fa_dline
  import fa_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_o  <= '0;
    end else if (inval_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag_i;
      line_o  <= fill_line_i;
    end
  end

  assign hit_o = valid_q && (tag_q == lk_tag_i);

  AST_DLINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o); // R6
endmodule

// File: rtl/fetch_accel.sv
module fetch_accel
  import fa_pkg::*;
#(
  parameter int AW      = 17,
  parameter int TIM_W   = 3,
  parameter int TIM_RST = 7,
  localparam int LIDX_W = AW - OFF_W,
  localparam int BTAG_W = LIDX_W - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_we_i,
  input  logic [1:0]            mode_i,
  input  logic                  tim_we_i,
  input  logic [TIM_W-1:0]      tim_i,
  input  logic                  prog_start_i,
  input  logic                  flash_busy_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [AW-1:0]         req_addr_i,
  input  logic                  req_data_i,
  input  logic                  req_seq_i,
  output logic                  rsp_valid_o,
  output logic [WORD_W-1:0]     rsp_rdata_o,
  output logic [1:0]            fl_en_o,
  output logic [2*BTAG_W-1:0]   fl_addr_o,
  input  logic [2*LINE_W-1:0]   fl_rdata_i
);
  logic [1:0]       mode_q;
  logic [TIM_W-1:0] tim_q;
  st_e              st_q;
  logic [TIM_W-1:0] cnt_q;
  logic             q_data, q_bank;
  logic [LIDX_W-1:0] q_line;
  logic [WSEL_W-1:0] q_widx;

  logic [LIDX_W-1:0] cur_line;
  logic              cur_bank;
  logic [WSEL_W-1:0] cur_widx;
  logic              accept, fast, comp, inval, pf_on;
  logic              ihit, dhit;
  logic [LINE_W-1:0] hit_line, dline;

  logic [1:0]        b_hit, b_pf_act, b_start, b_cancel, b_fill, b_dem;
  logic [LINE_W-1:0] b_line [2];
  logic [BTAG_W-1:0] b_ptag [2];

  logic              t1_fire, t2_fire, t2_bank;
  logic [LIDX_W-1:0] t1_line, t2_base, t2_line;

  assign cur_line = req_addr_i[AW-1:OFF_W];
  assign cur_bank = req_addr_i[OFF_W];
  assign cur_widx = req_addr_i[OFF_W-1:2];

  // configuration
  assign inval = prog_start_i |
                 (mode_we_i && mode_i != 2'b11 && mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      tim_q  <= TIM_W'(TIM_RST);
    end else begin
      if (mode_we_i && mode_i != 2'b11) mode_q <= mode_i;
      if (tim_we_i && tim_i != '0)      tim_q  <= tim_i;
    end
  end

  // hit decision
  assign ihit     = b_hit[cur_bank];
  assign hit_line = req_data_i ? dline : b_line[cur_bank];
  always_comb begin
    fast = 1'b0;
    if (mode_q == MODE_FULL)
      fast = req_data_i ? dhit : ihit;
    else if (mode_q == MODE_PART)
      fast = !req_data_i && req_seq_i && ihit;
  end

  assign req_ready_o = (st_q == ST_IDLE) && !flash_busy_i;
  assign accept      = req_valid_i && req_ready_o;
  assign comp        = (st_q == ST_WAIT) && (cnt_q == TIM_W'(1));
  assign pf_on       = (mode_q != MODE_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      q_data      <= 1'b0;
      q_bank      <= 1'b0;
      q_line      <= '0;
      q_widx      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept) begin
        if (fast) begin
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= hit_line[cur_widx*WORD_W +: WORD_W];
        end else begin
          st_q   <= ST_WAIT;
          cnt_q  <= tim_q;
          q_data <= req_data_i;
          q_bank <= cur_bank;
          q_line <= cur_line;
          q_widx <= cur_widx;
        end
      end else if (st_q == ST_WAIT) begin
        if (comp) begin
          st_q        <= ST_IDLE;
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= fl_rdata_i[{q_bank, q_widx}*WORD_W +: WORD_W];
        end else begin
          cnt_q <= cnt_q - TIM_W'(1);
        end
      end
    end
  end

  // prefetch triggers: opposite bank after a miss, same bank after word 3
  assign t1_fire = comp && !q_data && pf_on;
  assign t1_line = q_line + LIDX_W'(1);
  assign t2_fire = pf_on && ((accept && fast && !req_data_i && cur_widx == '1) ||
                             (comp && !q_data && q_widx == '1));
  assign t2_base = comp ? q_line : cur_line;
  assign t2_bank = t2_base[0];
  assign t2_line = t2_base + LIDX_W'(2);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign b_dem[b]    = (st_q == ST_WAIT) && (q_bank == 1'(b));
    assign b_fill[b]   = comp && !q_data && (q_bank == 1'(b));
    assign b_cancel[b] = flash_busy_i || (accept && !fast && cur_bank == 1'(b));
    assign b_start[b]  = (t1_fire && q_bank != 1'(b)) || (t2_fire && t2_bank == 1'(b));
    assign b_ptag[b]   = (t1_fire && q_bank != 1'(b)) ? t1_line[LIDX_W-1:1]
                                                      : t2_line[LIDX_W-1:1];
    fa_bank #(.TAG_W(BTAG_W), .TIM_W(TIM_W)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tim_i      (tim_q),
      .inval_i    (inval),
      .cancel_i   (b_cancel[b]),
      .pf_start_i (b_start[b]),
      .pf_tag_i   (b_ptag[b]),
      .dem_act_i  (b_dem[b]),
      .dem_tag_i  (q_line[LIDX_W-1:1]),
      .bt_fill_i  (b_fill[b]),
      .fl_rdata_i (fl_rdata_i[b*LINE_W +: LINE_W]),
      .fl_en_o    (fl_en_o[b]),
      .fl_addr_o  (fl_addr_o[b*BTAG_W +: BTAG_W]),
      .lk_tag_i   (cur_line[LIDX_W-1:1]),
      .hit_o      (b_hit[b]),
      .hit_line_o (b_line[b]),
      .pf_act_o   (b_pf_act[b])
    );
  end

  fa_dline #(.TAG_W(LIDX_W)) i_dline (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inval_i     (inval),
    .fill_i      (comp && q_data),
    .fill_tag_i  (q_line),
    .fill_line_i (fl_rdata_i[q_bank*LINE_W +: LINE_W]),
    .lk_tag_i    (cur_line),
    .hit_o       (dhit),
    .line_o      (dline)
  );

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11); // R6
  AST_TIM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tim_q != '0); // R5
  AST_FAST_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && fast) |=> rsp_valid_o); // R4
  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && cnt_q != TIM_W'(1)) |=> !rsp_valid_o); // R2
  AST_DEMAND_NO_PF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !b_pf_act[q_bank]); // R7
endmodule

// File: tb/test_fetch_accel.sv
module test_fetch_accel;
  localparam int AW = 17;
  localparam int BT = AW - 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0, tim_we = 0, prog = 0, busy = 0;
  logic [1:0] mode_v = 0;
  logic [2:0] tim_v = 0;
  logic req_v = 0, req_d = 0, req_s = 0;
  logic [AW-1:0] req_a = 0;
  logic rdy, rsp_v;
  logic [31:0] rsp_d;
  logic [1:0] fl_en;
  logic [2*BT-1:0] fl_addr;
  logic [255:0] fl_rdata;

  fetch_accel #(.AW(AW)) i_fetch_accel (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode_v),
    .tim_we_i(tim_we), .tim_i(tim_v), .prog_start_i(prog), .flash_busy_i(busy),
    .req_valid_i(req_v), .req_ready_o(rdy), .req_addr_i(req_a), .req_data_i(req_d),
    .req_seq_i(req_s), .rsp_valid_o(rsp_v), .rsp_rdata_o(rsp_d),
    .fl_en_o(fl_en), .fl_addr_o(fl_addr), .fl_rdata_i(fl_rdata));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;

  function automatic logic [31:0] mkword(int line, int w);
    return ((line * 4 + w) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // behavioural flash banks
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 4; w++) begin
        fl_rdata[b*128 + w*32 +: 32] = mkword({fl_addr[b*BT +: BT], 1'(b)}, w);
      end
    end
  end

  // reference model state
  int m_mode = 0, m_tim = 7;
  bit bt_v[2], pf_v[2];
  int bt_tag[2], pf_tag[2], pf_done[2];
  bit d_v = 0;
  int d_tag = 0;

  task automatic inval_all();
    for (int b = 0; b < 2; b++) begin
      bt_v[b] = 0; pf_v[b] = 0;
    end
    d_v = 0;
  endtask

  task automatic pf_start(int line, int s);
    int b = line % 2;
    pf_v[b] = 1; pf_tag[b] = (line / 2) % (1 << BT); pf_done[b] = s + m_tim;
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic [1:0] v);
    @(negedge clk);
    mode_we = 1; mode_v = v;
    @(negedge clk);
    mode_we = 0;
    if (v != 2'b11 && int'(v) != m_mode) begin
      m_mode = v; inval_all();
    end
  endtask

  task automatic set_tim(logic [2:0] v);
    @(negedge clk);
    tim_we = 1; tim_v = v;
    @(negedge clk);
    tim_we = 0;
    if (v != 0) m_tim = v;
  endtask

  task automatic access(int addr, bit dat, bit seq, string rq);
    int e, r, line, b, t, w;
    bit pfh, ih, dh, fast, ok;
    int lat_act;
    @(negedge clk);
    req_v = 1; req_a = AW'(addr); req_d = dat; req_s = seq;
    chk(rdy == 1'b1, rq, "ready", int'(rdy), 1);
    e = cyc + 1;
    line = (addr >> 4) % (1 << (AW-4)); b = line % 2; t = line / 2; w = (addr >> 2) % 4;
    pfh = pf_v[b] && pf_tag[b] == t && pf_done[b] < e;
    ih  = pfh || (bt_v[b] && bt_tag[b] == t);
    dh  = d_v && d_tag == line;
    fast = (m_mode == 2) ? (dat ? dh : ih) : (m_mode == 1) ? (!dat && seq && ih) : 0;
    r = fast ? e : e + m_tim;
    if (!fast) begin
      if (pf_v[b] && pf_done[b] >= e) pf_v[b] = 0;
      if (dat) begin d_v = 1; d_tag = line; end
      else begin
        bt_v[b] = 1; bt_tag[b] = t;
        if (m_mode != 0) pf_start(line + 1, r);
      end
    end
    if (!dat && m_mode != 0 && w == 3) pf_start(line + 2, r);
    @(negedge clk);
    req_v = 0;
    ok = 1; lat_act = -1;
    // compare on every clock until the expected response edge
    while (cyc <= r) begin
      if (rsp_v !== (cyc == r)) ok = 0;
      if (rsp_v && lat_act < 0) lat_act = cyc - e;
      if (cyc == r && rsp_v) chk(rsp_d == mkword(line, w), rq, "data R10", rsp_d, mkword(line, w));
      @(negedge clk);
    end
    chk(ok, rq, "latency", lat_act, r - e);
  endtask

  task automatic do_prog(int n);
    @(negedge clk);
    prog = 1; busy = 1;
    @(negedge clk);
    prog = 0;
    inval_all();
    for (int i = 0; i < n; i++) begin
      chk(rdy == 1'b0, "R9", "ready while busy", int'(rdy), 0);
      @(negedge clk);
    end
    busy = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    inval_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy == 1'b1, "R1", "reset ready", int'(rdy), 1);
    chk(rsp_v == 1'b0, "R1", "reset rsp", int'(rsp_v), 0);
    access('h000, 0, 0, "R1");
    access('h000, 0, 1, "R2");
    access('h100, 1, 0, "R2");
    access('h100, 1, 0, "R2");
    set_tim(0);
    access('h040, 0, 0, "R5");
    set_tim(3);
    access('h044, 0, 0, "R5");

    set_mode(2);
    access('h000, 0, 0, "R7");
    access('h010, 0, 1, "R7");   // back to back: prefetch still running
    access('h000, 0, 0, "R7");
    idle(5);
    access('h010, 0, 1, "R11");
    access('h004, 0, 1, "R4");
    access('h008, 0, 1, "R4");
    access('h00C, 0, 1, "R8");
    idle(5);
    access('h020, 0, 1, "R8");
    access('h014, 0, 1, "R4");
    access('h01C, 0, 1, "R8");
    idle(5);
    access('h030, 0, 1, "R8");
    access('h200, 1, 0, "R4");
    access('h204, 1, 0, "R4");
    access('h210, 1, 0, "R4");
    access('h200, 1, 0, "R4");
    access('h000, 0, 0, "R4");

    set_mode(2);
    access('h004, 0, 0, "R6");
    set_mode(3);
    access('h200, 1, 0, "R6");
    set_mode(1);
    access('h000, 0, 0, "R6");
    idle(4);
    access('h004, 0, 1, "R3");
    access('h008, 0, 0, "R3");
    access('h010, 0, 1, "R3");
    access('h200, 1, 0, "R3");
    access('h200, 1, 0, "R3");

    set_mode(2);
    set_tim(1);
    access('h080, 0, 0, "R5");
    access('h084, 0, 1, "R5");
    set_tim(2);
    access('h300, 1, 0, "R9");
    do_prog(4);
    access('h084, 0, 1, "R9");
    access('h300, 1, 0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule